// File: doc/BRIEF.md
# Programmable FIFO Entry to Protocol Word Unpacker

This block sits between a 32-bit transmit FIFO and a serial line shifter. It takes one FIFO entry at a time and breaks it into protocol words of 1 to 32 bits. Up to four small extraction steps, called vectors, are applied to each entry. Each vector copies a slice of up to eight bits out of the entry, walking either down or up from a programmed start bit. The slices are joined into the word being built. When the joined bits reach the configured bits-per-word, a word is presented on the output.

Software sets up the four vectors in two configuration words, and the bits-per-word value, before traffic starts. It leaves them unchanged while entries are flowing. Common layouts are four 8-bit-or-less words per entry, two 16-bit-or-less words, or one word of up to 32 bits. A layout can also build one word out of slices taken from several entries. Both handshakes are valid/ready. A stalled output freezes the vector sequencer without losing any state.

Top module: `fifo_word_unpacker`

## Requirements
- R1: After reset, word_valid_o is 0, entry_ready_o is 1, the sequencer is at vector 0 and the word under construction is empty.
- R2: Each vector is 10 bits: [9:5] start bit, [4] direction, [3:1] slice length minus one, [0] stop. Vector 0 is pack_cfg0_i[9:0], vector 1 is pack_cfg0_i[19:10], vector 2 is pack_cfg1_i[9:0] and vector 3 is pack_cfg1_i[19:10]. Vectors run in order 0, 1, 2, 3.
- R3: With direction 1, a slice takes entry bits start down to start-len. The start bit becomes the most significant bit of the slice.
- R4: With direction 0, a slice takes entry bits start up to start+len. The start bit becomes the most significant bit of the slice, so the bit order is reversed.
- R5: Each slice is appended below the bits already collected. A word is emitted once the collected bit count reaches bpw_i (1 to 32), and the collection then restarts empty.
- R6: A vector with its stop bit set is the last one applied to the current entry. The next entry starts again at vector 0, and the later vectors have no effect.
- R7: If no vector 0 to 2 carries a stop bit, the entry ends after vector 3 and the next entry starts at vector 0.
- R8: A partly built word carries over from one entry to the next, so one word may be built from slices of several entries.
- R9: While word_valid_o is 1 and word_ready_i is 0, word_valid_o stays 1 and word_o stays stable. Under any back-pressure pattern no word is lost or duplicated.
- R10: entry_ready_o is 1 only when no entry is held. An accepted entry drops entry_ready_o on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_i | input | 32 | FIFO entry |
| entry_valid_i | input | 1 | Entry valid |
| entry_ready_o | output | 1 | Entry can be accepted |
| pack_cfg0_i | input | 20 | Vectors 0 and 1 |
| pack_cfg1_i | input | 20 | Vectors 2 and 3 |
| bpw_i | input | 6 | Bits per protocol word, 1 to 32 |
| word_o | output | 32 | Protocol word, right-aligned |
| word_valid_o | output | 1 | Word valid |
| word_ready_i | input | 1 | Word accepted downstream |

## Verification
Four 7-bit words per entry taken most-significant-first check downward slices and the stop bit on vector 3. Two 15-bit words taken least-significant-first check bit reversal and words made from unequal slices. One 23-bit word per entry checks an early stop with the unused fourth vector ignored. A single 8-bit vector per entry with 16-bit words checks that a word carries across entries. A layout with no stop bit checks the end after vector 3. A back-pressure pattern on the 7-bit layout separates a correct stall from a lost or repeated word.

// File: rtl/unpack_pkg.sv
package unpack_pkg;
  localparam int unsigned ENTRY_W   = 32;
  localparam int unsigned VEC_W     = 10;
  localparam int unsigned NUM_VEC   = 4;
  localparam int unsigned SLICE_MAX = 8;
  localparam int unsigned VEC_PER_CFG = 2;
  localparam int unsigned CFG_W     = VEC_W * VEC_PER_CFG;
  localparam int unsigned IDX_W     = $clog2(ENTRY_W);
  localparam int unsigned CNT_W     = $clog2(ENTRY_W) + 1;
  localparam int unsigned LEN_W     = $clog2(SLICE_MAX);
  localparam int unsigned NB_W      = LEN_W + 1;
  localparam int unsigned VIDX_W    = $clog2(NUM_VEC);

  // field order matches the programmed bit layout, msb first
  typedef struct packed {
    logic [IDX_W-1:0] start;
    logic             dir;
    logic [LEN_W-1:0] len_m1;
    logic             stop;
  } pack_vec_t;
endpackage

// File: rtl/unpack_slice.sv
module unpack_slice
  import unpack_pkg::*;
(
  input  logic [ENTRY_W-1:0]   entry_i,
  input  pack_vec_t            vec_i,
  output logic [SLICE_MAX-1:0] slice_o,
  output logic [NB_W-1:0]      nbits_o
);
  logic [IDX_W-1:0] pos;

  // first bit taken lands in the most significant slice position
  always_comb begin
    slice_o = '0;
    pos     = '0;
    for (int k = 0; k < SLICE_MAX; k++) begin
      if (k <= int'(vec_i.len_m1)) begin
        pos     = vec_i.dir ? (vec_i.start - IDX_W'(k)) : (vec_i.start + IDX_W'(k));
        slice_o = {slice_o[SLICE_MAX-2:0], entry_i[pos]};
      end
    end
  end

  assign nbits_o = NB_W'(vec_i.len_m1) + NB_W'(1);
endmodule

// File: rtl/unpack_accum.sv
module unpack_accum
  import unpack_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic [SLICE_MAX-1:0] slice_i,
  input  logic [NB_W-1:0]      nbits_i,
  input  logic [CNT_W-1:0]     bpw_i,
  output logic                 done_o,
  output logic [ENTRY_W-1:0]   word_o
);
  logic [ENTRY_W-1:0] acc_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_nxt;
  logic               full;

  assign word_o  = (acc_q << nbits_i) | ENTRY_W'(slice_i);
  assign cnt_nxt = cnt_q + CNT_W'(nbits_i);
  assign full    = cnt_nxt >= bpw_i;
  assign done_o  = step_i && full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      if (full) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= word_o;
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/fifo_word_unpacker.sv
module fifo_word_unpacker
  import unpack_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRY_W-1:0] entry_i,
  input  logic               entry_valid_i,
  output logic               entry_ready_o,
  input  logic [CFG_W-1:0]   pack_cfg0_i,
  input  logic [CFG_W-1:0]   pack_cfg1_i,
  input  logic [CNT_W-1:0]   bpw_i,
  output logic [ENTRY_W-1:0] word_o,
  output logic               word_valid_o,
  input  logic               word_ready_i
);
  localparam int unsigned NUM_CFG = NUM_VEC / VEC_PER_CFG;

  logic [CFG_W-1:0]   cfg_w [NUM_CFG];
  pack_vec_t          vecs  [NUM_VEC];
  pack_vec_t          cur_vec;
  logic [ENTRY_W-1:0] ent_q;
  logic               ent_vld_q;
  logic [VIDX_W-1:0]  vec_idx_q;
  logic               out_vld_q;
  logic [ENTRY_W-1:0] out_q;
  logic               step, last;
  logic [SLICE_MAX-1:0] slice;
  logic [NB_W-1:0]    nbits;
  logic               done;
  logic [ENTRY_W-1:0] acc_word;

  assign cfg_w[0] = pack_cfg0_i;
  assign cfg_w[1] = pack_cfg1_i;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    assign vecs[g] = pack_vec_t'(cfg_w[g / VEC_PER_CFG][(g % VEC_PER_CFG) * VEC_W +: VEC_W]);
  end

  assign cur_vec       = vecs[vec_idx_q];
  assign last          = cur_vec.stop || (vec_idx_q == VIDX_W'(NUM_VEC - 1));
  assign step          = ent_vld_q && (!out_vld_q || word_ready_i);
  assign entry_ready_o = !ent_vld_q;

  unpack_slice u_slice (
    .entry_i (ent_q),
    .vec_i   (cur_vec),
    .slice_o (slice),
    .nbits_o (nbits)
  );

  unpack_accum u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .slice_i (slice),
    .nbits_i (nbits),
    .bpw_i   (bpw_i),
    .done_o  (done),
    .word_o  (acc_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q     <= '0;
      ent_vld_q <= 1'b0;
      vec_idx_q <= '0;
    end else begin
      if (!ent_vld_q && entry_valid_i) begin
        ent_q     <= entry_i;
        ent_vld_q <= 1'b1;
      end else if (step && last) begin
        ent_vld_q <= 1'b0;
      end
      if (step) vec_idx_q <= last ? '0 : vec_idx_q + VIDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_q     <= '0;
    end else if (done) begin
      out_vld_q <= 1'b1;
      out_q     <= acc_word;
    end else if (word_ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  assign word_o       = out_q;
  assign word_valid_o = out_vld_q;
endmodule

// File: rtl/fifo_word_unpacker_chk.sv
module fifo_word_unpacker_chk
  import unpack_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               entry_valid_i,
  input logic               entry_ready_o,
  input logic               word_valid_o,
  input logic               word_ready_i,
  input logic [ENTRY_W-1:0] word_o,
  input logic [VIDX_W-1:0]  vec_idx
);
  a_r9_valid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> word_valid_o);

  a_r9_word_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o && !word_ready_i |=> $stable(word_o));

  a_r10_entry_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && entry_ready_o |=> !entry_ready_o);

  a_r6_idle_at_vec0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_ready_o |-> vec_idx == '0);

  a_r6_new_entry_vec0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && entry_ready_o |=> vec_idx == '0);
endmodule

bind fifo_word_unpacker fifo_word_unpacker_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .entry_valid_i (entry_valid_i),
  .entry_ready_o (entry_ready_o),
  .word_valid_o  (word_valid_o),
  .word_ready_i  (word_ready_i),
  .word_o        (word_o),
  .vec_idx       (vec_idx_q)
);

// File: tb/fifo_word_unpacker_test.sv
module fifo_word_unpacker_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] entry = 0;
  logic        entry_valid = 0;
  logic        entry_ready;
  logic [19:0] cfg0 = 0, cfg1 = 0;
  logic [5:0]  bpw = 8;
  logic [31:0] word;
  logic        word_valid;
  logic        rdy = 1;
  logic        bp_mode = 0;
  logic [7:0]  lfsr = 8'h5a;
  logic        prev_stall = 0;
  logic [31:0] prev_word = 0;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fifo_word_unpacker uut (
    .clk_i(clk), .rst_ni(rst_n), .entry_i(entry), .entry_valid_i(entry_valid),
    .entry_ready_o(entry_ready), .pack_cfg0_i(cfg0), .pack_cfg1_i(cfg1),
    .bpw_i(bpw), .word_o(word), .word_valid_o(word_valid), .word_ready_i(rdy)
  );

  function automatic logic [9:0] mkv(int st, bit dir, int lm1, bit stop);
    return {5'(st), dir, 3'(lm1), stop};
  endfunction

  function automatic logic [31:0] rev(logic [31:0] x, int n);
    logic [31:0] r = 0;
    for (int i = 0; i < n; i++) r[n-1-i] = x[i];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // output monitor: ready chosen first, then handshake recorded (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check("R9 valid held", 32'(word_valid), 32'd1);
        check("R9 word stable", word, prev_word);
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy  = bp_mode ? lfsr[0] : 1'b1;
      if (word_valid && rdy) got_q.push_back(word);
      prev_stall = word_valid && !rdy;
      prev_word  = word;
    end
  end

  task automatic push(logic [31:0] d);
    @(negedge clk);
    entry = d;
    entry_valid = 1;
    while (!entry_ready) @(negedge clk);
    @(negedge clk);
    entry_valid = 0;
    check("R10 ready drops after accept", 32'(entry_ready), 32'd0);
  endtask

  task automatic drain_cmp(string req);
    repeat (120) @(negedge clk);
    check({req, " word count"}, 32'(got_q.size()), 32'(exp_q.size()));
    while (exp_q.size() > 0 && got_q.size() > 0)
      check(req, got_q.pop_front(), exp_q.pop_front());
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic t_reset();
    check("R1 no word after reset", 32'(word_valid), 32'd0);
    check("R1 entry ready after reset", 32'(entry_ready), 32'd1);
  endtask

  task automatic t_msb7x4();
    logic [31:0] d[2] = '{32'h9ab3_c5e7, 32'h1f2e_3d4c};
    cfg0 = {mkv(14,1,6,0), mkv(6,1,6,0)};
    cfg1 = {mkv(30,1,6,1), mkv(22,1,6,0)};
    bpw = 7;
    foreach (d[i]) begin
      exp_q.push_back(d[i][6:0]);   exp_q.push_back(d[i][14:8]);
      exp_q.push_back(d[i][22:16]); exp_q.push_back(d[i][30:24]);
    end
    foreach (d[i]) push(d[i]);
    drain_cmp("R2 R3 R6 msb 7x4");
  endtask

  task automatic t_lsb15x2();
    logic [31:0] d[2] = '{32'h6b3d_8e15, 32'ha5c3_0ff1};
    cfg0 = {mkv(8,0,6,0), mkv(0,0,7,0)};
    cfg1 = {mkv(24,0,6,1), mkv(16,0,7,0)};
    bpw = 15;
    foreach (d[i]) begin
      exp_q.push_back(rev(d[i], 15));
      exp_q.push_back(rev(d[i] >> 16, 15));
    end
    foreach (d[i]) push(d[i]);
    drain_cmp("R4 R5 lsb 15x2");
  endtask

  task automatic t_msb23();
    logic [31:0] d[2] = '{32'hde4c_a937, 32'h0132_fe5b};
    cfg0 = {mkv(14,1,7,0), mkv(22,1,7,0)};
    cfg1 = {mkv(31,0,7,0), mkv(6,1,6,1)};
    bpw = 23;
    foreach (d[i]) exp_q.push_back({9'd0, d[i][22:0]});
    foreach (d[i]) push(d[i]);
    drain_cmp("R3 R6 msb 23 early stop");
  endtask

  task automatic t_span16();
    logic [31:0] d[4] = '{32'h0000_00a1, 32'hffff_ff5c, 32'h1234_5633, 32'h0f0f_0fe4};
    cfg0 = {mkv(3,0,7,1), mkv(7,1,7,1)};
    cfg1 = {mkv(9,1,2,0), mkv(20,0,4,0)};
    bpw = 16;
    exp_q.push_back({16'd0, d[0][7:0], d[1][7:0]});
    exp_q.push_back({16'd0, d[2][7:0], d[3][7:0]});
    foreach (d[i]) push(d[i]);
    drain_cmp("R8 span entries");
  endtask

  task automatic t_nostop();
    logic [31:0] d[2] = '{32'h8844_2211, 32'hc3b2_a190};
    cfg0 = {mkv(15,1,7,0), mkv(7,1,7,0)};
    cfg1 = {mkv(31,1,7,0), mkv(23,1,7,0)};
    bpw = 8;
    foreach (d[i])
      for (int b = 0; b < 4; b++) exp_q.push_back(32'(d[i][b*8 +: 8]));
    foreach (d[i]) push(d[i]);
    drain_cmp("R7 end after vector 3");
  endtask

  task automatic t_backpressure();
    logic [31:0] d[3] = '{32'h7766_5544, 32'h1357_9bdf, 32'h2468_ace0};
    cfg0 = {mkv(14,1,6,0), mkv(6,1,6,0)};
    cfg1 = {mkv(30,1,6,1), mkv(22,1,6,0)};
    bpw = 7;
    bp_mode = 1;
    foreach (d[i]) begin
      exp_q.push_back(d[i][6:0]);   exp_q.push_back(d[i][14:8]);
      exp_q.push_back(d[i][22:16]); exp_q.push_back(d[i][30:24]);
    end
    foreach (d[i]) push(d[i]);
    drain_cmp("R9 back-pressure");
    bp_mode = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_msb7x4();
    t_lsb15x2();
    t_msb23();
    t_span16();
    t_nostop();
    t_backpressure();
    finish_run();
  end
endmodule